// File: doc/BRIEF.md
# Eight-Bit Timer With Shared Prescaler

This block is an 8-bit up-counter that raises a sticky interrupt flag each time it wraps from 255 to 0. Its increments come either from the instruction-cycle strobe (one pulse per four oscillator clocks) or from an external pin. The pin can be counted on its rising or on its falling edge. One 8-bit prescaler is shared between the counter and a watchdog. When the prescaler serves the counter, a 3-bit rate field divides the count source by 2 to 256. When it serves the watchdog, the counter counts every source event and the watchdog oscillator ticks are divided instead.

External edges go into the prescaler directly. Only the prescaler's output is brought into the system clock domain, through a small synchronizer. This lets pin events outrun the instruction strobe when the prescaler is in use. Software loads the counter with a preload value. The time to overflow is (256 − preload) × prescale instruction cycles, plus a fixed hold-off of two instruction cycles after every load. A load also empties the prescaler, so each timed interval starts from a known phase.

Top module: `tmr8_presc_top`

## Requirements
- R1: In reset, count_out, ovf_flag and wdt_tick are all 0.
- R2: A cycle with wr_en high loads wr_data into count_out, which shows it on the next cycle. The counter then ignores its increment source until two insn_tick pulses have passed.
- R3: When pre_to_wdt=0 and src_ext=0, the counter advances once per 2^(rate_sel+1) insn_tick pulses (rate_sel 0..7 gives 1:2 .. 1:256). After loading P, the wrap to 0 therefore comes on insn_tick number 2 + (256−P)·2^(rate_sel+1).
- R4: When pre_to_wdt=1 and src_ext=0, the counter advances on every insn_tick pulse (1:1).
- R5: An increment from 255 to 0 sets ovf_flag in the same clock that count_out becomes 0. ovf_flag then stays 1 until a cycle with flag_clr high clears it. A new wrap wins over flag_clr. A counter load does not touch the flag.
- R6: With src_ext=1 and edge_fall=0, each rising edge on ext_in is counted and falling edges have no effect on count_out.
- R7: With src_ext=1 and edge_fall=1, each falling edge on ext_in is counted and rising edges have no effect on count_out.
- R8: With src_ext=1 and pre_to_wdt=0, the counter advances once per 2^(rate_sel+1) selected edges. The prescaled signal is synchronized to clk after the prescaler.
- R9: A counter load clears the prescaler, so prescaler events counted before the load do not carry over into the next increment.
- R10: wdt_tick is a registered one-clock pulse. With pre_to_wdt=1 it comes once per 2^(rate_sel+1) wdt_src_tick pulses. With pre_to_wdt=0 it follows each wdt_src_tick one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_tick | input | 1 | Instruction-cycle strobe, one clock per four oscillator clocks |
| ext_in | input | 1 | External count pin, asynchronous |
| src_ext | input | 1 | 1 selects ext_in as count source, 0 selects insn_tick |
| edge_fall | input | 1 | 1 counts falling ext_in edges, 0 counts rising |
| pre_to_wdt | input | 1 | 1 assigns the prescaler to the watchdog, 0 to the counter |
| rate_sel | input | 3 | Prescale select, ratio 2^(rate_sel+1) |
| wdt_src_tick | input | 1 | Watchdog oscillator tick |
| wr_en | input | 1 | Load strobe for the counter |
| wr_data | input | 8 | Value to load |
| flag_clr | input | 1 | Clears the overflow flag |
| count_out | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Tick pulse toward the watchdog |

## Verification
The assertions run on every cycle. They check that the counter only holds, steps by one or loads. They check that a load shows the written value and freezes the counter for the two-tick hold-off, and that a 255-to-0 step always comes with the flag. They also check that the flag persists until cleared, and that wdt_tick mirrors the watchdog source when the prescaler belongs to the counter. The division ratios, the overflow delay for every rate, the rejection of the unselected edge, and the prescaler clear on a load depend on long event histories. Only the bench scenarios show these: they sweep every rate in internal mode and count edges and watchdog pulses against arithmetic expectations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Mask of the prescaler bits that must all be one for a terminal event
  // at ratio 2^(rate+1).
  function automatic logic [255:0] rate_mask(input int unsigned rate, input int unsigned width);
    logic [255:0] m;
    m = '0;
    for (int i = 0; i < 256; i++) begin
      if (i < width && i <= rate) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int RATE_W = 3,
  localparam int PRE_W = 1 << RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              evt,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              term,
  output logic              tap
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'(tmr_pkg::rate_mask(int'(rate_sel), PRE_W));
    term = evt && ((cnt & mask) == mask);
    tap  = cnt[rate_sel];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (evt)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W      = 8,
  parameter int HOLD_TICKS = 2,
  localparam int HW = $clog2(HOLD_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_tick,
  input  logic             inc_req,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             hold_busy
);
  logic [HW-1:0] hold;
  logic          inc;
  logic          wrap;

  assign hold_busy = (hold != '0);
  assign inc       = inc_req && !hold_busy && !wr_en;
  assign wrap      = inc && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_en)                  hold <= HW'(HOLD_TICKS);
      else if (insn_tick && hold_busy) hold <= hold - 1'b1;

      if (wr_en)    count <= wr_data;
      else if (inc) count <= count + 1'b1;

      if (wrap)          ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr8_presc_top.sv
module tmr8_presc_top #(
  parameter int CNT_W       = 8,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_tick,
  input  logic              ext_in,
  input  logic              src_ext,
  input  logic              edge_fall,
  input  logic              pre_to_wdt,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              wdt_src_tick,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count_out,
  output logic              ovf_flag,
  output logic              wdt_tick
);
  logic ext_lvl, ext_prev, ext_rise;
  logic hold_busy;
  logic pre_evt, pre_term, pre_tap;
  logic sync_d, sync_q, sync_prev, ext_inc;
  logic int_inc, inc_req;

  // Capture the pin with polarity applied; edges feed the prescaler directly.
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_lvl  <= 1'b0;
      ext_prev <= 1'b0;
    end else begin
      ext_lvl  <= ext_in ^ edge_fall;
      ext_prev <= ext_lvl;
    end
  end
  assign ext_rise = ext_lvl && !ext_prev;

  assign pre_evt = pre_to_wdt ? wdt_src_tick
                              : ((src_ext ? ext_rise : insn_tick) && !hold_busy);

  tmr_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(wr_en), .evt(pre_evt),
    .rate_sel(rate_sel), .term(pre_term), .tap(pre_tap)
  );

  // Synchronization sits after the prescaler; the inverted tap rises at
  // every 2^(rate+1)-th event.
  assign sync_d = pre_to_wdt ? ext_lvl : !pre_tap;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sync_d), .q(sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_prev <= 1'b1;
    else     sync_prev <= sync_q;
  end
  assign ext_inc = sync_q && !sync_prev;

  assign int_inc = insn_tick && (pre_to_wdt || pre_term);
  assign inc_req = src_ext ? ext_inc : int_inc;

  tmr_core #(.CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) u_core (
    .clk(clk), .rst(rst), .insn_tick(insn_tick), .inc_req(inc_req),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .count(count_out), .ovf_flag(ovf_flag), .hold_busy(hold_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_tick <= 1'b0;
    else     wdt_tick <= pre_to_wdt ? pre_term : wdt_src_tick;
  end
endmodule

// File: rtl/tmr8_presc_chk.sv
module tmr8_presc_chk #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_tick,
  input logic              pre_to_wdt,
  input logic              wdt_src_tick,
  input logic              wr_en,
  input logic [CNT_W-1:0]  wr_data,
  input logic              flag_clr,
  input logic [CNT_W-1:0]  count_out,
  input logic              ovf_flag,
  input logic              wdt_tick
);
  logic [1:0] ticks_left;

  always_ff @(posedge clk) begin
    if (rst)                              ticks_left <= 2'd0;
    else if (wr_en)                       ticks_left <= 2'd2;
    else if (insn_tick && ticks_left != 0) ticks_left <= ticks_left - 2'd1;
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (count_out == $past(count_out)) || (count_out == $past(count_out) + 1'b1));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> count_out == $past(wr_data));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && ticks_left != 0) |=> $stable(count_out));

  assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && count_out == {CNT_W{1'b1}}) |=> (count_out == '0) ? ovf_flag : 1'b1);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  assert_wdt_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (!pre_to_wdt && wdt_src_tick) |=> wdt_tick);

  assert_wdt_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !wdt_src_tick |=> !wdt_tick);
endmodule

bind tmr8_presc_top tmr8_presc_chk #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .insn_tick(insn_tick), .pre_to_wdt(pre_to_wdt),
  .wdt_src_tick(wdt_src_tick), .wr_en(wr_en), .wr_data(wr_data),
  .flag_clr(flag_clr), .count_out(count_out), .ovf_flag(ovf_flag),
  .wdt_tick(wdt_tick)
);

// File: tb/tmr8_presc_top_bench.sv
module tmr8_presc_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       insn_tick = 1'b0, ext_in = 1'b0, src_ext = 1'b0, edge_fall = 1'b0;
  logic       pre_to_wdt = 1'b0, wdt_src_tick = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count_out;
  logic       ovf_flag, wdt_tick;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tmr8_presc_top u_tmr8_presc_top (
    .clk(clk), .rst(rst), .insn_tick(insn_tick), .ext_in(ext_in),
    .src_ext(src_ext), .edge_fall(edge_fall), .pre_to_wdt(pre_to_wdt),
    .rate_sel(rate_sel), .wdt_src_tick(wdt_src_tick), .wr_en(wr_en),
    .wr_data(wr_data), .flag_clr(flag_clr), .count_out(count_out),
    .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
  );

  task automatic check(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); insn_tick = 1'b1;
    @(negedge clk); insn_tick = 1'b0;
    settle(2);
  endtask

  task automatic pin(input logic v);
    @(negedge clk); ext_in = v;
    settle(8);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    settle(5);
    check(count_out, 0, "R1 count");
    check(ovf_flag, 0, "R1 flag");
    check(wdt_tick, 0, "R1 wdt_tick");
    @(negedge clk); rst = 1'b0;
    settle(2);

    // R3 internal, prescaler on counter, every rate
    for (int r = 0; r < 8; r++) begin
      int n;
      n = 2 << r;
      rate_sel = 3'(r);
      clear_flag();
      load(8'd253);
      check(count_out, 253, "R2 load value");
      for (int t = 1; t <= 2 + 3 * n; t++) begin
        tick();
        if (t == 1 + n)     check(count_out, 253, "R3 before first step");
        if (t == 2 + n)     check(count_out, 254, "R3 first step");
        if (t == 1 + 3 * n) begin
          check(count_out, 255, "R3 before wrap");
          check(ovf_flag, 0, "R5 flag before wrap");
        end
        if (t == 2 + 3 * n) begin
          check(count_out, 0, "R3 wrap delay");
          check(ovf_flag, 1, "R5 flag at wrap");
        end
      end
    end

    // R4 prescaler on watchdog: 1:1, with R2 hold-off
    pre_to_wdt = 1'b1;
    clear_flag();
    load(8'd250);
    tick(); tick();
    check(count_out, 250, "R2 hold-off two ticks");
    tick();
    check(count_out, 251, "R4 one per tick");
    for (int t = 0; t < 5; t++) tick();
    check(count_out, 0, "R4 wrap");
    check(ovf_flag, 1, "R5 flag set");
    load(8'd100);
    check(ovf_flag, 1, "R5 load keeps flag");
    for (int t = 0; t < 5; t++) tick();
    check(ovf_flag, 1, "R5 flag sticky");
    clear_flag();
    check(ovf_flag, 0, "R5 flag cleared");

    // R9 load clears prescaler
    pre_to_wdt = 1'b0;
    rate_sel = 3'd1;
    load(8'd40);
    for (int t = 0; t < 5; t++) tick();
    load(8'd40);
    for (int t = 0; t < 5; t++) tick();
    check(count_out, 40, "R9 partial prescale discarded");
    tick();
    check(count_out, 41, "R9 step after full prescale");

    // R6 external rising, prescaler bypassed
    src_ext = 1'b1; pre_to_wdt = 1'b1; edge_fall = 1'b0; ext_in = 1'b0;
    settle(12);
    load(8'd10);
    tick(); tick();
    for (int k = 1; k <= 4; k++) begin
      pin(1'b1);
      check(count_out, 10 + k, "R6 rising counted");
      pin(1'b0);
      check(count_out, 10 + k, "R6 falling ignored");
    end

    // R7 external falling
    edge_fall = 1'b1; ext_in = 1'b1;
    settle(12);
    load(8'd20);
    tick(); tick();
    for (int k = 1; k <= 4; k++) begin
      pin(1'b0);
      check(count_out, 20 + k, "R7 falling counted");
      pin(1'b1);
      check(count_out, 20 + k, "R7 rising ignored");
    end

    // R8 external through prescaler
    pre_to_wdt = 1'b0; edge_fall = 1'b0; ext_in = 1'b0;
    for (int r = 0; r < 3; r++) begin
      int n;
      n = 2 << r;
      rate_sel = 3'(r);
      settle(12);
      load(8'd30);
      tick(); tick();
      for (int k = 1; k <= 2 * n + 1; k++) begin
        pin(1'b1);
        pin(1'b0);
        check(count_out, 30 + k / n, "R8 prescaled edges");
      end
    end

    // R10 watchdog ticks
    src_ext = 1'b0;
    for (int mode = 0; mode < 2; mode++) begin
      int n, seen;
      pre_to_wdt = mode[0];
      rate_sel = 3'd2;
      n = mode ? 8 : 1;
      settle(4);
      load(8'd0);
      seen = 0;
      for (int p = 0; p < 3 * 8 + 1; p++) begin
        @(negedge clk); wdt_src_tick = 1'b1;
        @(negedge clk); wdt_src_tick = 1'b0;
        if (wdt_tick) seen++;
        @(negedge clk);
        if (wdt_tick) seen++;
      end
      check(seen, (3 * 8 + 1) / n, "R10 watchdog tick count");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule